// File: doc/BRIEF.md
# External Interrupt and Wakeup Controller

This block watches a group of external interrupt pins. Each line is set up on its own: it detects either transitions or levels, and it treats either the high/rising sense or the low/falling sense as active. The main-clock path brings each pin through a synchronizer and keeps a pending flag per line. It raises a single interrupt request when any pending line is also enabled.

A second copy of the detection logic runs on an always-on clock, so that the block can still recognise pin activity while the main clock is stopped. It drives a one-cycle wake pulse to the power manager, according to the current power mode. In the two deep low-power modes, a line can wake the device even with its interrupt disabled, provided the pin is configured for its special function. In idle, only enabled interrupts wake the device: enabled external lines, or an already-enabled request from another source. A companion flag tells the core whether to enter the service routine after waking or to resume in-line.

Top module: `extint_wake_ctrl`

## Requirements
- R1: While rst_n is low, pending_o, irq_o, wake_o and wake_isr_o are all 0.
- R2: Each pin passes through a two-flop synchronizer. A pin change applied between clock edges shows up on pending_o on the third rising clk edge after it, and not earlier.
- R3: In edge mode (edge_mode_i bit = 1), a line with rise_high_i = 1 sets its pending bit on a 0-to-1 transition, and a line with rise_high_i = 0 sets it on a 1-to-0 transition. The transition of the opposite direction has no effect. Once set, the bit stays set after the pin returns to its idle level.
- R4: In edge mode, a pulse on pend_clr_i clears that line's pending bit. If a new transition arrives in the same cycle as the clear, the bit stays set.
- R5: In level mode (edge_mode_i bit = 0), the pending bit follows the active level: pin high when rise_high_i = 1, pin low when rise_high_i = 0. It drops when the level goes inactive, and pend_clr_i has no effect on it.
- R6: irq_o is 1 exactly when some line has both its pending bit and its irq_en_i bit set. A pending line that is disabled raises no request.
- R7: pmode_i encodes run = 0, idle = 1, standby = 2, powerdown = 3. In run mode wake_o stays 0 whatever the pins do.
- R8: In standby or powerdown, an active line whose sfi_i bit is 1 produces a wake even when its irq_en_i bit is 0. A line whose sfi_i bit is 0 produces none.
- R9: In idle, a line wakes only if its irq_en_i bit is 1. other_irq_i, which carries an enabled request from any other source, also wakes. An active line that has sfi_i = 1 but is disabled does not wake.
- R10: wake_o is a single aon_clk cycle pulse at the onset of each wake condition, even when the level stays active.
- R11: wake_isr_o is updated with each wake pulse and holds until the next one. It is 1 if a waking line has its interrupt enabled, or if the wake in idle came from other_irq_i; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| aon_clk | input | 1 | Always-on clock for the wake path |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_LINES | Raw external interrupt pins |
| edge_mode_i | input | NUM_LINES | 1 = edge detection, 0 = level detection |
| rise_high_i | input | NUM_LINES | 1 = rising/high active, 0 = falling/low active |
| irq_en_i | input | NUM_LINES | Per-line interrupt enable |
| sfi_i | input | NUM_LINES | Pin configured as special-function input |
| pmode_i | input | 2 | Power mode: 0 run, 1 idle, 2 standby, 3 powerdown |
| other_irq_i | input | 1 | Enabled request from another interrupt source (aon_clk domain) |
| pend_clr_i | input | NUM_LINES | Per-line pending clear pulse |
| pending_o | output | NUM_LINES | Pending flags |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake pulse to power management |
| wake_isr_o | output | 1 | Take the service routine after the last wake |

## Verification
The clear of an edge-mode pending bit and the arrival of a fresh transition on the same line can land on one clock edge. The bench first sets the bit, then starts a second transition timed so that the pulse on pend_clr_i covers exactly the edge where the synchronized transition is registered. The bit must still read 1. A lone clear afterwards must bring it to 0. The wake pulse and the service-routine flag are produced on the same edge. Each wake scenario is therefore judged on both: the pulse count, and the flag value that follows it.

// File: rtl/extint_pkg.sv
package extint_pkg;
   typedef enum logic [1:0] {
      PM_RUN       = 2'd0,
      PM_IDLE      = 2'd1,
      PM_STANDBY   = 2'd2,
      PM_POWERDOWN = 2'd3
   } pmode_e;

   function automatic logic pm_is_deep(input pmode_e m);
      return (m == PM_STANDBY) || (m == PM_POWERDOWN);
   endfunction
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("extint_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d_i;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/extint_sense.sv
module extint_sense (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic rise_high_i,
   output logic evt_o,
   output logic act_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;

   always_comb begin
      if (rise_high_i) begin
         act_o = lvl_i;
         evt_o = lvl_i & ~prev_q;
      end else begin
         act_o = ~lvl_i;
         evt_o = ~lvl_i & prev_q;
      end
   end
endmodule

// File: rtl/extint_pend_line.sv
module extint_pend_line (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_mode_i,
   input  logic evt_i,
   input  logic act_i,
   input  logic clr_i,
   output logic pend_o
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pend_q <= 1'b0;
      else if (edge_mode_i) pend_q <= (pend_q & ~clr_i) | evt_i;
      else                  pend_q <= act_i;
   end

   assign pend_o = pend_q;

   // R3: a latched edge survives until software clears it
   assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode_i && pend_q && !clr_i) |=> pend_q);

   // R4: a fresh transition beats a simultaneous clear
   assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode_i && evt_i && clr_i) |=> pend_q);

   // R5: in level mode an active level is latched even during a clear
   assert_level_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_mode_i && act_i && clr_i) |=> pend_q);
endmodule

// File: rtl/extint_wake.sv
module extint_wake
   import extint_pkg::*;
#(
   parameter int NUM_LINES   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 aon_clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pin_i,
   input  logic [NUM_LINES-1:0] edge_mode_i,
   input  logic [NUM_LINES-1:0] rise_high_i,
   input  logic [NUM_LINES-1:0] irq_en_i,
   input  logic [NUM_LINES-1:0] sfi_i,
   input  logic [1:0]           pmode_i,
   input  logic                 other_irq_i,
   output logic                 wake_o,
   output logic                 wake_isr_o
);
   logic [NUM_LINES-1:0] lvl_s, evt_s, act_s, hit_s;
   pmode_e mode;
   logic   cond, cond_en, cond_d, wake_q, isr_q, onset;

   assign mode = pmode_e'(pmode_i);

   extint_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(aon_clk), .rst_n(rst_n), .d_i(pin_i), .q_o(lvl_s)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      extint_sense u_sense (
         .clk(aon_clk), .rst_n(rst_n), .lvl_i(lvl_s[i]),
         .rise_high_i(rise_high_i[i]), .evt_o(evt_s[i]), .act_o(act_s[i])
      );
      assign hit_s[i] = edge_mode_i[i] ? evt_s[i] : act_s[i];
   end

   always_comb begin
      cond    = 1'b0;
      cond_en = 1'b0;
      if (pm_is_deep(mode)) begin
         cond    = |(hit_s & sfi_i);
         cond_en = |(hit_s & sfi_i & irq_en_i);
      end else if (mode == PM_IDLE) begin
         cond    = |(hit_s & irq_en_i) | other_irq_i;
         cond_en = cond;
      end
   end

   assign onset = cond & ~cond_d;

   always_ff @(posedge aon_clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_d <= 1'b0;
         wake_q <= 1'b0;
         isr_q  <= 1'b0;
      end else begin
         cond_d <= cond;
         wake_q <= onset;
         if (onset) isr_q <= cond_en;
      end
   end

   assign wake_o     = wake_q;
   assign wake_isr_o = isr_q;

   // R10: the wake output never lasts longer than one cycle
   assert_wake_single_R10: assert property (@(posedge aon_clk) disable iff (!rst_n)
      wake_o |=> !wake_o);

   // R7: no wake pulse follows a cycle spent in run mode
   assert_no_wake_run_R7: assert property (@(posedge aon_clk) disable iff (!rst_n)
      wake_o |-> ($past(pmode_i) != 2'd0));

   // R8: a deep-mode wake needs some special-function line
   assert_deep_sfi_R8: assert property (@(posedge aon_clk) disable iff (!rst_n)
      (wake_o && ($past(pmode_i) >= 2'd2)) |-> ($past(sfi_i) != '0));
endmodule

// File: rtl/extint_wake_ctrl.sv
module extint_wake_ctrl #(
   parameter int NUM_LINES   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 aon_clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pin_i,
   input  logic [NUM_LINES-1:0] edge_mode_i,
   input  logic [NUM_LINES-1:0] rise_high_i,
   input  logic [NUM_LINES-1:0] irq_en_i,
   input  logic [NUM_LINES-1:0] sfi_i,
   input  logic [1:0]           pmode_i,
   input  logic                 other_irq_i,
   input  logic [NUM_LINES-1:0] pend_clr_i,
   output logic [NUM_LINES-1:0] pending_o,
   output logic                 irq_o,
   output logic                 wake_o,
   output logic                 wake_isr_o
);
   if (NUM_LINES < 1 || NUM_LINES > 32) begin : g_bad_lines
      $error("extint_wake_ctrl: NUM_LINES must lie in 1..32");
   end

   logic [NUM_LINES-1:0] lvl_m, evt_m, act_m;

   extint_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(lvl_m)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      extint_sense u_sense (
         .clk(clk), .rst_n(rst_n), .lvl_i(lvl_m[i]),
         .rise_high_i(rise_high_i[i]), .evt_o(evt_m[i]), .act_o(act_m[i])
      );
      extint_pend_line u_pend (
         .clk(clk), .rst_n(rst_n), .edge_mode_i(edge_mode_i[i]),
         .evt_i(evt_m[i]), .act_i(act_m[i]), .clr_i(pend_clr_i[i]),
         .pend_o(pending_o[i])
      );
   end

   assign irq_o = |(pending_o & irq_en_i);

   extint_wake #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_wake (
      .aon_clk(aon_clk), .rst_n(rst_n), .pin_i(pin_i),
      .edge_mode_i(edge_mode_i), .rise_high_i(rise_high_i),
      .irq_en_i(irq_en_i), .sfi_i(sfi_i), .pmode_i(pmode_i),
      .other_irq_i(other_irq_i), .wake_o(wake_o), .wake_isr_o(wake_isr_o)
   );

   // R6: a request needs at least one pending line
   assert_irq_has_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (pending_o != '0));
endmodule

// File: tb/extint_wake_ctrl_test.sv
`timescale 1ns/1ps
module extint_wake_ctrl_test;
   localparam int N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] pin = '0, edge_mode = '0, rise_high = '0, irq_en = '0, sfi = '0, clr = '0;
   logic [1:0] pmode = 2'd0;
   logic other = 1'b0;
   logic [N-1:0] pending;
   logic irq, wake, wake_isr;

   int checks = 0, fails = 0, wake_cnt = 0;
   bit done = 0;

   always #5 clk = ~clk;

   extint_wake_ctrl #(.NUM_LINES(N), .SYNC_STAGES(2)) uut (
      .clk(clk), .aon_clk(clk), .rst_n(rst_n), .pin_i(pin),
      .edge_mode_i(edge_mode), .rise_high_i(rise_high), .irq_en_i(irq_en),
      .sfi_i(sfi), .pmode_i(pmode), .other_irq_i(other), .pend_clr_i(clr),
      .pending_o(pending), .irq_o(irq), .wake_o(wake), .wake_isr_o(wake_isr)
   );

   always @(negedge clk) if (rst_n && wake) wake_cnt++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; pin = '0; clr = '0; other = 1'b0;
      cyc(3);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      edge_mode = '1; rise_high = '1; irq_en = '1; sfi = '1; pmode = 2'd2;
      rst_n = 1'b0; pin = 4'hF;
      cyc(4);
      chk("R1 pending", int'(pending), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 wake", int'(wake), 0);
      chk("R1 wake_isr", int'(wake_isr), 0);
      pin = '0;
   endtask

   task automatic t_edge_rise();
      edge_mode = '1; rise_high = '1; irq_en = '0; sfi = '0; pmode = 2'd0;
      do_reset(); cyc(2);
      pin[0] = 1'b1;
      cyc(2); chk("R2 not before third edge", int'(pending[0]), 0);
      cyc(1); chk("R2 R3 rising sets", int'(pending[0]), 1);
      pin[0] = 1'b0;
      cyc(4); chk("R3 held after release", int'(pending[0]), 1);
   endtask

   task automatic t_edge_fall();
      edge_mode = '1; rise_high = 4'b1101; irq_en = '0; sfi = '0; pmode = 2'd0;
      do_reset(); cyc(2);
      pin[1] = 1'b1;
      cyc(4); chk("R3 rising ignored on falling line", int'(pending[1]), 0);
      pin[1] = 1'b0;
      cyc(4); chk("R3 falling sets", int'(pending[1]), 1);
   endtask

   task automatic t_clear_race();
      edge_mode = '1; rise_high = '1; irq_en = '0; sfi = '0; pmode = 2'd0;
      do_reset(); cyc(2);
      pin[2] = 1'b1; cyc(4); pin[2] = 1'b0; cyc(4);
      chk("R4 preset", int'(pending[2]), 1);
      pin[2] = 1'b1;
      cyc(2); clr[2] = 1'b1;
      cyc(1); clr[2] = 1'b0;
      chk("R4 set wins over clear", int'(pending[2]), 1);
      cyc(2);
      clr[2] = 1'b1; cyc(1); clr[2] = 1'b0;
      chk("R4 clear", int'(pending[2]), 0);
   endtask

   task automatic t_level();
      edge_mode = '0; rise_high = 4'b0111; irq_en = '0; sfi = '0; pmode = 2'd0;
      do_reset(); cyc(4);
      chk("R5 low-active line pending at low pin", int'(pending[3]), 1);
      pin[3] = 1'b1; cyc(4);
      chk("R5 low-active drops", int'(pending[3]), 0);
      pin[0] = 1'b1; cyc(4);
      chk("R5 high-active follows", int'(pending[0]), 1);
      clr[0] = 1'b1; cyc(1); clr[0] = 1'b0; cyc(1);
      chk("R5 clear ignored", int'(pending[0]), 1);
      pin[0] = 1'b0; cyc(4);
      chk("R5 drops when inactive", int'(pending[0]), 0);
   endtask

   task automatic t_irq();
      edge_mode = '1; rise_high = '1; irq_en = 4'b0010; sfi = '0; pmode = 2'd0;
      do_reset(); cyc(2);
      pin[0] = 1'b1; cyc(4);
      chk("R6 disabled pending no irq", int'(irq), 0);
      pin[1] = 1'b1; cyc(4);
      chk("R6 enabled pending irq", int'(irq), 1);
      clr[1] = 1'b1; cyc(1); clr[1] = 1'b0; cyc(1);
      chk("R6 irq drops after clear", int'(irq), 0);
   endtask

   task automatic t_run();
      int base;
      edge_mode = '1; rise_high = '1; irq_en = '1; sfi = '1; pmode = 2'd0;
      do_reset(); cyc(2);
      base = wake_cnt;
      pin = 4'hF; cyc(6);
      chk("R7 no wake in run", wake_cnt - base, 0);
   endtask

   task automatic t_deep();
      int base;
      edge_mode = '0; rise_high = '1; irq_en = '0; sfi = 4'b0001; pmode = 2'd2;
      do_reset(); cyc(2);
      base = wake_cnt;
      pin[1] = 1'b1; cyc(6);
      chk("R8 no wake without sfi", wake_cnt - base, 0);
      pin[0] = 1'b1; cyc(8);
      chk("R8 R10 disabled sfi line wakes once", wake_cnt - base, 1);
      chk("R11 isr flag clear when disabled", int'(wake_isr), 0);
      pin = '0; irq_en = 4'b0001; pmode = 2'd3; cyc(4);
      base = wake_cnt;
      pin[0] = 1'b1; cyc(6);
      chk("R8 powerdown wake", wake_cnt - base, 1);
      chk("R11 isr flag set when enabled", int'(wake_isr), 1);
   endtask

   task automatic t_idle();
      int base;
      edge_mode = '1; rise_high = '1; irq_en = 4'b0100; sfi = '1; pmode = 2'd1;
      do_reset(); cyc(2);
      base = wake_cnt;
      pin[0] = 1'b1; cyc(6);
      chk("R9 disabled line no idle wake", wake_cnt - base, 0);
      pin[2] = 1'b1; cyc(6);
      chk("R9 enabled line wakes idle", wake_cnt - base, 1);
      chk("R11 isr after idle line wake", int'(wake_isr), 1);
      base = wake_cnt;
      other = 1'b1; cyc(3); other = 1'b0; cyc(3);
      chk("R9 R10 other source wakes once", wake_cnt - base, 1);
   endtask

   initial begin
      t_reset();
      t_edge_rise();
      t_edge_fall();
      t_clear_race();
      t_level();
      t_irq();
      t_run();
      t_deep();
      t_idle();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule